// File: doc/BRIEF.md
# Single-Cycle-Per-Bit Sequential Multiplier

This block multiplies two unsigned WIDTH-bit operands by repeated shift-and-add and handles one multiplier bit per clock. Its two operand registers are filled from one shared operand bus by two separate load strobes, and a start request begins the calculation. Each working cycle adds the multiplicand into the upper half of the product when the current low bit of the multiplier is 1. The sum is then shifted right one place together with the multiplier register, and the adder carry lands straight in the top bit. No carry flop is kept between the two steps.

A two-state controller (idle, run) and a down counter set the sequence. The counter is loaded with WIDTH-1 when a start is accepted. It counts down on every run cycle, and the run cycle that sees it at zero is the last. The product is the concatenation of the accumulator (high half) and the multiplier register (low half). It can be read whenever the block is idle. A one-cycle done pulse marks the moment the result becomes valid, and busy is high for exactly WIDTH cycles per multiplication.

Top module: `smul_onestep`

## Requirements
- R1: After reset, busy and done are 0 and the product output is all zeros.
- R2: While idle, a high load_mcand captures opnd_in into the multiplicand register, and a high load_mplier captures opnd_in into the multiplier register, which appears in product[WIDTH-1:0] one cycle later while product[2*WIDTH-1:WIDTH] keeps its value.
- R3: While idle, a high go is accepted at the next clock edge: the high half of the product clears and busy is 1 from the next cycle on.
- R4: When a run ends, product equals the unsigned product of the multiplicand and multiplier held at the start edge (all 256 operand pairs for WIDTH=4).
- R5: Busy stays high for exactly WIDTH cycles after the start edge, and the result and the done pulse both appear WIDTH cycles after the start edge.
- R6: Done is a single-cycle pulse.
- R7: A go request while busy has no effect: the run length and the result are unchanged.
- R8: load_mcand and load_mplier while busy have no effect on the result of the run in progress.
- R9: While idle with no strobe and no go, the product output holds its value.
- R10: The adder carry-out reaches the product's high bit without a separate carry flop, so 15 x 15 gives 225 for WIDTH=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request, taken only while idle |
| load_mcand | input | 1 | Load the multiplicand register from opnd_in while idle |
| load_mplier | input | 1 | Load the multiplier register from opnd_in while idle |
| opnd_in | input | WIDTH | Shared operand bus |
| product | output | 2*WIDTH | Accumulator high half, multiplier register low half |
| busy | output | 1 | High while a multiplication runs |
| done | output | 1 | One-cycle pulse when the result becomes valid |

## Verification
A start accepted at edge k makes busy high from k+1. The product and the done pulse are due after edge k+WIDTH, and done drops again after edge k+WIDTH+1. A load strobe in idle shows in the product one edge later. The bench drives inputs on falling edges and keeps a behavioural model that steps on rising edges. It compares busy, done and the idle product on every falling edge. It also makes directed checks at the exact falling edge where each result is due, counted from the edge that accepted the start.

// File: rtl/smul_pkg.sv
package smul_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } smul_state_t;
endpackage

// File: rtl/smul_seq.sv
module smul_seq
   import smul_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic start,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WIDTH - 1);

   smul_state_t       state;
   logic [CNT_W-1:0]  cnt;
   logic              last;
   logic              done_r;

   always_comb begin
      start = (state == ST_IDLE) && go;
      step  = (state == ST_RUN);
      last  = step && (cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         done_r <= 1'b0;
      end else begin
         done_r <= last;
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  state <= ST_RUN;
                  cnt   <= CNT_INIT;
               end
            end
            ST_RUN: begin
               cnt <= cnt - 1'b1;
               if (cnt == '0) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = step;
   assign done = done_r;

   // R3
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (state == ST_RUN && cnt == CNT_INIT));

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt != '0) |=> (state == ST_RUN && cnt == CNT_W'($past(cnt) - 1'b1)));

   // R5
   finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (state == ST_IDLE && done_r));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_r |=> !done_r);

   // R7
   go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && go && cnt != '0) |=> (state == ST_RUN));
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
   parameter int WIDTH = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               step,
   input  logic               ld_b,
   input  logic               ld_q,
   input  logic [WIDTH-1:0]   opnd,
   output logic [2*WIDTH-1:0] product
);
   localparam int SUM_W = WIDTH + 1;

   logic [WIDTH-1:0] a_r;
   logic [WIDTH-1:0] b_r;
   logic [WIDTH-1:0] q_r;
   logic [SUM_W-1:0] addend;
   logic [SUM_W-1:0] sum;

   always_comb begin
      addend = q_r[0] ? {1'b0, b_r} : '0;
      sum    = {1'b0, a_r} + addend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_r <= '0;
         b_r <= '0;
         q_r <= '0;
      end else if (step) begin
         a_r <= sum[SUM_W-1:1];
         q_r <= {sum[0], q_r[WIDTH-1:1]};
      end else begin
         if (start) a_r <= '0;
         if (ld_b)  b_r <= opnd;
         if (ld_q)  q_r <= opnd;
      end
   end

   assign product = {a_r, q_r};

   // R8
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> $stable(b_r));

   // R2
   q_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && ld_q) |=> (q_r == $past(opnd)));

   // R3
   a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && start) |=> (a_r == '0));
endmodule

// File: rtl/smul_onestep.sv
module smul_onestep #(
   parameter int WIDTH = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               load_mcand,
   input  logic               load_mplier,
   input  logic [WIDTH-1:0]   opnd_in,
   output logic [2*WIDTH-1:0] product,
   output logic               busy,
   output logic               done
);
   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("smul_onestep: WIDTH must be at least 2");
      end
   endgenerate

   logic start;
   logic step;

   smul_seq #(.WIDTH(WIDTH)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .start (start),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   smul_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .step    (step),
      .ld_b    (load_mcand),
      .ld_q    (load_mplier),
      .opnd    (opnd_in),
      .product (product)
   );
endmodule

// File: tb/test_smul_onestep.sv
`timescale 1ns/1ps
module test_smul_onestep;
   localparam int W  = 4;
   localparam int PW = 2 * W;
   localparam int LOW_MASK = (1 << W) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go = 1'b0;
   logic          ld_b = 1'b0;
   logic          ld_q = 1'b0;
   logic [W-1:0]  opnd = '0;
   logic [PW-1:0] product;
   logic          busy;
   logic          done;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 0;

   // behavioural reference state
   bit m_busy = 0;
   bit m_done = 0;
   int m_cnt = 0;
   int m_b = 0;
   int m_q = 0;
   int m_prod = 0;

   always #4 clk = ~clk;

   smul_onestep #(.WIDTH(W)) i_smul_onestep (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .load_mcand  (ld_b),
      .load_mplier (ld_q),
      .opnd_in     (opnd),
      .product     (product),
      .busy        (busy),
      .done        (done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_b = 0; m_q = 0; m_prod = 0;
      end else if (!m_busy) begin
         m_done = 0;
         if (ld_b) m_b = int'(opnd);
         if (ld_q) begin
            m_q = int'(opnd);
            m_prod = (m_prod & ~LOW_MASK) | int'(opnd);
         end
         if (go) begin
            m_busy = 1;
            m_cnt = W;
            m_prod = m_prod & LOW_MASK;
         end
      end else begin
         m_done = 0;
         m_cnt--;
         if (m_cnt == 0) begin
            m_busy = 0;
            m_done = 1;
            m_prod = m_b * m_q;
         end
      end
   end

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(busy == m_busy, "R5 busy vs model", int'(busy), int'(m_busy));
         check(done == m_done, "R6 done vs model", int'(done), int'(m_done));
         if (!m_busy)
            check(int'(product) == m_prod, "R4 idle product vs model", int'(product), m_prod);
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1;
         failures++;
         $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   // poke: 0 none, 1 go while busy, 2 loads while busy
   task automatic run_mul(input int b, input int q, input int poke, input string tag);
      @(negedge clk);
      ld_b = 1'b1; opnd = W'(b);
      @(negedge clk);
      ld_b = 1'b0; ld_q = 1'b1; go = 1'b1; opnd = W'(q);
      @(negedge clk);
      ld_q = 1'b0; go = 1'b0;
      check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
      check(product[PW-1:W] == '0, "R3 high half cleared", int'(product[PW-1:W]), 0);
      if (poke == 1) go = 1'b1;
      if (poke == 2) begin
         ld_b = 1'b1; ld_q = 1'b1; opnd = W'(~b);
      end
      for (int i = 0; i < W; i++) begin
         @(negedge clk);
         go = 1'b0; ld_b = 1'b0; ld_q = 1'b0;
         if (i < W - 1)
            check(busy == 1'b1 && done == 1'b0, "R5 still running",
                  int'({busy, done}), 2);
      end
      check(done == 1'b1 && busy == 1'b0, "R5 done after WIDTH cycles",
            int'({busy, done}), 1);
      check(int'(product) == b * q, tag, int'(product), b * q);
      @(negedge clk);
      check(done == 1'b0, "R6 done falls", int'(done), 0);
   endtask

   initial begin
      int hold_val;
      repeat (2) @(negedge clk);
      // R1 reset state
      check(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'({busy, done}), 0);
      check(product == '0, "R1 reset product", int'(product), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 load multiplier in idle
      ld_q = 1'b1; opnd = 4'd5;
      @(negedge clk);
      ld_q = 1'b0;
      check(product[W-1:0] == 4'd5, "R2 low half loaded", int'(product[W-1:0]), 5);
      check(product[PW-1:W] == '0, "R2 high half kept", int'(product[PW-1:W]), 0);

      // R10 carry into top bit
      run_mul(15, 15, 0, "R10 max operands");
      // R7 go while busy
      run_mul(11, 13, 1, "R7 go ignored while busy");
      // R8 loads while busy
      run_mul(9, 6, 2, "R8 loads ignored while busy");

      // R9 hold in idle
      hold_val = int'(product);
      repeat (4) begin
         @(negedge clk);
         check(int'(product) == hold_val, "R9 idle hold", int'(product), hold_val);
      end

      // R4 exhaustive operand pairs
      for (int b = 0; b < (1 << W); b++)
         for (int q = 0; q < (1 << W); q++)
            run_mul(b, q, 0, "R4 product");

      finished = 1;
      finish_run();
   end
endmodule